// File: doc/BRIEF.md
# Reload Timer with Edge-Triggered Capture

This block is an 8-bit down-counter that reloads from a programmable latch. It counts one of four prescaled versions of the system clock, or edges seen on an external input pin. Writing n to the latch makes the counter divide its count source by n+1. On each underflow the counter reloads and raises an underflow interrupt request.

The same input pin is synchronized, edge-detected and used to raise a second interrupt request. In the two measurement modes, each qualifying pin edge captures the running count into a read-only register and restarts the count from the latch. The pin event can be a rising edge or a falling edge. In the high/low pulse-width mode, every edge counts.

Software uses a small register bus. It writes the latch, the mode register and the flag-clear register, and reads the counter, the mode register, the capture register and the flags. Both interrupt outputs are the flag levels.

Top module: `reload_capture_timer`

## Requirements
- R1: After reset, every readable location returns 0 and both interrupt outputs are low.
- R2: In timer mode (mode field 0) with divide-by-1, a run write that registers on clock edge P1 makes the counter step down once per clock from P2. The counter underflows on edge P(n+2). On underflow it reloads from the latch, and irq_underflow rises on that same edge.
- R3: The source field (mode register bits 5:4) selects a divide of 1, 16, 256 or 1024 (codes 0..3). With latch n, the first underflow comes 16·(n+1) clocks after the run edge for code 1, and 256·(n+1) clocks after it for code 2.
- R4: Address 0 holds the latch. A latch write while stopped also loads the counter. A latch write while running changes only the latch, and the new value is used at the next reload.
- R5: While the run bit (mode register bit 3) is 0, the counter holds its value.
- R6: The polarity bit (mode register bit 2) selects the edge that sets irq_pin: falling when it is 0, rising when it is 1. The flag is visible three clock edges after the pin changes. The other edge has no effect.
- R7: In high/low pulse-width mode (mode field 3), both pin edges set irq_pin and capture, whatever the polarity bit says.
- R8: In event-counter mode (mode field 1), the counter steps down once per qualifying pin edge instead of once per prescaler tick. Its underflow behaves as in R2.
- R9: In period mode (mode field 2), a qualifying edge copies the counter value into the capture register (read at address 2) and reloads the counter from the latch. A non-qualifying edge changes neither register.
- R10: A mode-register write while running leaves the source field unchanged and updates every other field. While stopped, all fields take the written value.
- R11: Writing address 2 clears the underflow flag when data bit 0 is 1, and clears the pin flag when data bit 1 is 1. A flag being set in the same cycle wins over the clear. Address 3 reads {pin flag, underflow flag} in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 latch, 1 mode, 2 flag clear |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address: 0 counter, 1 mode, 2 capture, 3 flags |
| rd_data | output | 8 | Read data, combinational from registers |
| pin_in | input | 1 | Asynchronous count/measure input |
| irq_underflow | output | 1 | Underflow interrupt request flag |
| irq_pin | output | 1 | Pin-edge interrupt request flag |

## Verification
The underflow flag rises on edge P(n+2) after a divide-by-1 run edge P1, and on P(1+16·(n+1)) for divide-by-16. The bench samples one negedge before and exactly on that edge. A pin change reaches the flag, the capture register and the event counter three rising edges after it is driven. Each task therefore drives the pin just after a falling clock edge and samples three falling edges later; the latency check also samples one edge early. Register writes take effect on the next rising edge, so every readback happens at the falling edge after the write.

// File: rtl/rct_pkg.sv
package rct_pkg;
    typedef enum logic [1:0] {
        MODE_TIMER  = 2'd0,
        MODE_EVENT  = 2'd1,
        MODE_PERIOD = 2'd2,
        MODE_PWHL   = 2'd3
    } rct_mode_e;

    localparam logic [1:0] ADDR_COUNT = 2'd0;
    localparam logic [1:0] ADDR_MODE  = 2'd1;
    localparam logic [1:0] ADDR_CAPT  = 2'd2;
    localparam logic [1:0] ADDR_FLAG  = 2'd3;

    // Qualifying pin edge: both edges in pulse-width mode, else per polarity
    function automatic logic edge_qualifies(rct_mode_e m, logic pol, logic rise, logic fall);
        if (m == MODE_PWHL) return rise | fall;
        return pol ? rise : fall;
    endfunction
endpackage

// File: rtl/rct_prescaler.sv
module rct_prescaler #(
    parameter int DIV_SH1 = 4,
    parameter int DIV_SH2 = 8,
    parameter int DIV_SH3 = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic [1:0] sel_i,
    output logic       tick_o
);
    localparam int PW = DIV_SH3;
    localparam logic [PW-1:0] MASK1 = PW'((64'd1 << DIV_SH1) - 64'd1);
    localparam logic [PW-1:0] MASK2 = PW'((64'd1 << DIV_SH2) - 64'd1);
    localparam logic [PW-1:0] MASK3 = PW'((64'd1 << DIV_SH3) - 64'd1);

    logic [PW-1:0] cnt_d, cnt_q, mask;

    always_comb begin
        case (sel_i)
            2'd0:    mask = '0;
            2'd1:    mask = MASK1;
            2'd2:    mask = MASK2;
            default: mask = MASK3;
        endcase
        cnt_d  = run_i ? cnt_q + PW'(1) : '0;
        tick_o = run_i && ((cnt_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3
    single_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && sel_i != 2'd0 && tick_o) |=> !tick_o);
endmodule

// File: rtl/rct_edge_sync.sv
module rct_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] sync_d, sync_q;
    logic              prev_d, prev_q;

    assign sync_d[0] = pin_i;
    for (genvar g = 1; g < STAGES; g++) begin : g_chain
        assign sync_d[g] = sync_q[g-1];
    end

    always_comb begin
        prev_d = sync_q[STAGES-1];
        rise_o = sync_q[STAGES-1] & ~prev_q;
        fall_o = ~sync_q[STAGES-1] & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    // R6
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/rct_core.sv
module rct_core
    import rct_pkg::*;
#(
    parameter int W = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  rct_mode_e mode_i,
    input  logic      pol_i,
    input  logic      run_i,
    input  logic      tick_i,
    input  logic      rise_i,
    input  logic      fall_i,
    input  logic [W-1:0] latch_i,
    input  logic      load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] count_o,
    output logic [W-1:0] capt_o,
    output logic      uf_o,
    output logic      edge_o
);
    typedef struct packed {
        logic [W-1:0] count;
        logic [W-1:0] capt;
    } core_t;

    core_t st_d, st_q;
    logic  qual, measure, step;

    always_comb begin
        st_d    = st_q;
        uf_o    = 1'b0;
        qual    = edge_qualifies(mode_i, pol_i, rise_i, fall_i);
        measure = (mode_i == MODE_PERIOD) || (mode_i == MODE_PWHL);
        case (mode_i)
            MODE_TIMER: step = tick_i;
            MODE_EVENT: step = qual;
            default:    step = tick_i && !qual;
        endcase
        if (load_i) begin
            st_d.count = load_val_i;
        end else if (run_i) begin
            if (measure && qual) begin
                st_d.capt  = st_q.count;
                st_d.count = latch_i;
            end else if (step) begin
                if (st_q.count == '0) begin
                    st_d.count = latch_i;
                    uf_o       = 1'b1;
                end else begin
                    st_d.count = st_q.count - W'(1);
                end
            end
        end
        edge_o  = qual;
        count_o = st_q.count;
        capt_o  = st_q.capt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    reload_on_uf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uf_o |=> (count_o == $past(latch_i)));
    // R5
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> $stable(count_o));
    // R9
    capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !load_i && edge_o && (mode_i == MODE_PERIOD || mode_i == MODE_PWHL))
        |=> (capt_o == $past(count_o)));
endmodule

// File: rtl/reload_capture_timer.sv
module reload_capture_timer
    import rct_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_SH1     = 4,
    parameter int DIV_SH2     = 8,
    parameter int DIV_SH3     = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   rd_addr,
    output logic [W-1:0] rd_data,
    input  logic         pin_in,
    output logic         irq_underflow,
    output logic         irq_pin
);
    typedef struct packed {
        logic [W-1:0] latch;
        rct_mode_e    mode;
        logic         pol;
        logic         run;
        logic [1:0]   src;
        logic         uf;
        logic         pin;
    } regs_t;

    regs_t        r_d, r_q;
    logic         tick, rise, fall, load, uf_pulse, edge_pulse;
    logic [W-1:0] count, capt;

    rct_prescaler #(.DIV_SH1(DIV_SH1), .DIV_SH2(DIV_SH2), .DIV_SH3(DIV_SH3)) u_pre (
        .clk(clk), .rst_n(rst_n), .run_i(r_q.run), .sel_i(r_q.src), .tick_o(tick)
    );

    rct_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_in), .rise_o(rise), .fall_o(fall)
    );

    rct_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .mode_i(r_q.mode), .pol_i(r_q.pol), .run_i(r_q.run),
        .tick_i(tick), .rise_i(rise), .fall_i(fall), .latch_i(r_q.latch),
        .load_i(load), .load_val_i(wr_data), .count_o(count), .capt_o(capt),
        .uf_o(uf_pulse), .edge_o(edge_pulse)
    );

    always_comb begin
        r_d  = r_q;
        load = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                ADDR_COUNT: begin
                    r_d.latch = wr_data;
                    load      = !r_q.run;
                end
                ADDR_MODE: begin
                    r_d.mode = rct_mode_e'(wr_data[1:0]);
                    r_d.pol  = wr_data[2];
                    r_d.run  = wr_data[3];
                    if (!r_q.run) r_d.src = wr_data[5:4];
                end
                ADDR_CAPT: begin
                    if (wr_data[0]) r_d.uf  = 1'b0;
                    if (wr_data[1]) r_d.pin = 1'b0;
                end
                default: ;
            endcase
        end
        if (uf_pulse)   r_d.uf  = 1'b1;
        if (edge_pulse) r_d.pin = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (rd_addr)
            ADDR_COUNT: rd_data = count;
            ADDR_MODE:  rd_data = W'({r_q.src, r_q.run, r_q.pol, r_q.mode});
            ADDR_CAPT:  rd_data = capt;
            default:    rd_data = W'({r_q.pin, r_q.uf});
        endcase
        irq_underflow = r_q.uf;
        irq_pin       = r_q.pin;
    end

    // R10
    src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_MODE && r_q.run) |=> (r_q.src == $past(r_q.src)));
    // R11
    uf_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uf_pulse |=> irq_underflow);
    // R6
    pin_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_pulse |=> irq_pin);
    // R11
    uf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_CAPT && wr_data[0] && !uf_pulse) |=> !irq_underflow);
endmodule

// File: tb/reload_capture_timer_tb.sv
module reload_capture_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       pin_in = 1'b0;
    logic       irq_underflow, irq_pin;
    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    reload_capture_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pin_in(pin_in),
        .irq_underflow(irq_underflow), .irq_pin(irq_pin)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic clear_all();
        wr(2'd2, 8'h03);
    endtask

    task automatic t_reset();
        int v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1 reset readback", v, 0);
        end
        check("R1 reset irq_underflow", int'(irq_underflow), 0);
        check("R1 reset irq_pin", int'(irq_pin), 0);
    endtask

    task automatic t_timer_div1();
        int v;
        wr(2'd0, 8'd5);
        rd(2'd0, v); check("R4 stopped latch write loads counter", v, 5);
        wr(2'd1, 8'h08);
        step(5);
        check("R2 no underflow before edge n+2", int'(irq_underflow), 0);
        step(1);
        check("R2 underflow flag on edge n+2", int'(irq_underflow), 1);
        rd(2'd0, v); check("R2 counter reloaded", v, 5);
        rd(2'd3, v); check("R11 flag register bit0", v, 1);
        wr(2'd1, 8'h00);
        clear_all();
        check("R11 underflow flag cleared", int'(irq_underflow), 0);
    endtask

    task automatic t_running_latch();
        int v;
        wr(2'd0, 8'd3);
        wr(2'd1, 8'h08);
        step(2);
        wr(2'd0, 8'd9);
        rd(2'd0, v); check("R4 running latch write keeps count", v, 0);
        step(1);
        rd(2'd0, v); check("R4 new latch used at reload", v, 9);
        check("R2 underflow after running latch write", int'(irq_underflow), 1);
        wr(2'd1, 8'h00);
        clear_all();
    endtask

    task automatic t_stop();
        int v0, v1;
        rd(2'd0, v0);
        step(6);
        rd(2'd0, v1);
        check("R5 counter frozen while stopped", v1, v0);
    endtask

    task automatic t_prescale();
        wr(2'd0, 8'd1);
        wr(2'd1, 8'h18);
        step(31);
        check("R3 div16 no underflow at 31", int'(irq_underflow), 0);
        step(1);
        check("R3 div16 underflow at 32", int'(irq_underflow), 1);
        wr(2'd1, 8'h00);
        clear_all();
        wr(2'd0, 8'd0);
        wr(2'd1, 8'h28);
        step(255);
        check("R3 div256 no underflow at 255", int'(irq_underflow), 0);
        step(1);
        check("R3 div256 underflow at 256", int'(irq_underflow), 1);
        wr(2'd1, 8'h00);
        clear_all();
    endtask

    task automatic t_src_lock();
        int v;
        wr(2'd1, 8'h08);
        wr(2'd1, 8'h3C);
        rd(2'd1, v); check("R10 source kept while running", v, 8'h0C);
        wr(2'd1, 8'h00);
        wr(2'd1, 8'h30);
        rd(2'd1, v); check("R10 source written while stopped", v, 8'h30);
        wr(2'd1, 8'h00);
        clear_all();
    endtask

    task automatic t_edge_pol();
        pin_in = 1'b1; step(3);
        check("R6 rising ignored with polarity 0", int'(irq_pin), 0);
        pin_in = 1'b0; step(3);
        check("R6 falling sets flag with polarity 0", int'(irq_pin), 1);
        wr(2'd2, 8'h02);
        check("R11 pin flag cleared", int'(irq_pin), 0);
        wr(2'd1, 8'h04);
        pin_in = 1'b1; step(2);
        check("R6 flag not yet after two edges", int'(irq_pin), 0);
        step(1);
        check("R6 rising sets flag with polarity 1", int'(irq_pin), 1);
        clear_all();
        pin_in = 1'b0; step(3);
        check("R6 falling ignored with polarity 1", int'(irq_pin), 0);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_event();
        int v;
        wr(2'd0, 8'd2);
        wr(2'd1, 8'h0D);
        for (int i = 0; i < 3; i++) begin
            pin_in = 1'b1; step(3);
            rd(2'd0, v);
            check("R8 count after rising edge", v, (i == 2) ? 2 : 1 - i);
            pin_in = 1'b0; step(3);
            rd(2'd0, v);
            check("R8 falling edge does not count", v, (i == 2) ? 2 : 1 - i);
        end
        check("R8 underflow after n+1 edges", int'(irq_underflow), 1);
        wr(2'd1, 8'h00);
        clear_all();
    endtask

    task automatic t_period();
        int v;
        wr(2'd0, 8'd100);
        wr(2'd1, 8'h0E);
        step(10);
        pin_in = 1'b1; step(3);
        rd(2'd2, v); check("R9 capture on rising edge", v, 88);
        rd(2'd0, v); check("R9 counter restarted", v, 100);
        check("R6 pin flag in period mode", int'(irq_pin), 1);
        pin_in = 1'b0; step(3);
        rd(2'd2, v); check("R9 falling edge no capture", v, 88);
        rd(2'd0, v); check("R9 falling edge no restart", v, 97);
        wr(2'd1, 8'h06);
        clear_all();
    endtask

    task automatic t_pwhl();
        int v;
        wr(2'd0, 8'd50);
        wr(2'd1, 8'h0B);
        step(4);
        pin_in = 1'b1; step(3);
        rd(2'd2, v); check("R7 capture on rising edge", v, 44);
        check("R7 rising sets flag with polarity 0", int'(irq_pin), 1);
        wr(2'd2, 8'h02);
        check("R7 flag cleared", int'(irq_pin), 0);
        pin_in = 1'b0; step(3);
        rd(2'd2, v); check("R7 capture on falling edge", v, 47);
        check("R7 falling sets flag", int'(irq_pin), 1);
        wr(2'd1, 8'h00);
        clear_all();
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_timer_div1();
        t_running_latch();
        t_stop();
        t_prescale();
        t_src_lock();
        t_edge_pol();
        t_event();
        t_period();
        t_pwhl();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule